// File: doc/BRIEF.md
# Masked Ternary Search Table

The block holds a small table of 72-bit ternary entries. Every entry stores a data word, a care word and a live bit. A host loads entries through a write port and programs a file of global mask registers. A search command then compares one 72-bit key against the whole table and returns the lowest matching location.

A search takes two consecutive command cycles. The first cycle (A) carries the key, a global-mask pair index and a result-register index. The second cycle (B) carries the same key and a comparand pair index. The key is written into both registers of the chosen comparand pair. The winning address goes out on the result port and into the chosen result register, together with a hit flag. Searches can be issued every two cycles. The address appears a fixed four cycles after cycle A. The valid and hit strobes can be pushed further back by a small configurable delay.

Top module: `tcam_search72`

## Requirements
- R1: While reset is held and after its release, res_addr is 0, res_valid and res_hit are 0, every result register reads address 0 with hit 0, and every comparand register reads 0.
- R2: A live entry matches when, for every bit position where both the effective global mask and the entry's care word hold 1, the key bit equals the entry data bit. A 0 in either mask makes that bit don't-care.
- R3: When several live entries match, the lowest address is reported.
- R4: An entry written with tw_live = 0 never matches, whatever its data and care words hold.
- R5: The global mask pair index given in cycle A selects registers 2p and 2p+1 of the mask file. The effective mask is the bitwise AND of the two registers.
- R6: The key given in cycle B is written into comparand registers 2c and 2c+1, where c is the pair index given in cycle B. All other comparand registers keep their values.
- R7: The result register chosen by cmd_rsel in cycle A receives the winning address and the hit flag of that search.
- R8: res_addr takes the search's result at the fourth rising edge after the edge that samples cycle A. res_valid and res_hit pulse for one cycle lat_extra cycles after that. res_addr does not change at any other time.
- R9: A search with no matching entry reports hit 0 and address 0, and its valid pulse still occurs at the normal time.
- R10: Searches issued back to back, one every two cycles (cycle B always directly after cycle A), each produce their own result, in issue order.
- R11: A table write completed before a search's cycle A is seen by that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | AW | Table entry address |
| tw_data | input | KW | Entry data word |
| tw_care | input | KW | Entry care word (1 = compare) |
| tw_live | input | 1 | Entry live bit |
| gm_we | input | 1 | Global mask register write strobe |
| gm_sel | input | GSW | Global mask register number |
| gm_wdata | input | KW | Global mask write data (1 = compare) |
| cmd_a | input | 1 | Search cycle A |
| cmd_b | input | 1 | Search cycle B |
| cmd_key | input | KW | Search key, same value in A and B |
| cmd_gpair | input | GSW-1 | Global mask pair index (cycle A) |
| cmd_cpair | input | CSW-1 | Comparand pair index (cycle B) |
| cmd_rsel | input | RSW | Result register index (cycle A) |
| lat_extra | input | LATW | Extra strobe delay in cycles |
| cr_rd_sel | input | CSW | Comparand register read select |
| cr_rd_data | output | KW | Comparand register read data |
| rr_rd_sel | input | RSW | Result register read select |
| rr_rd_addr | output | AW | Result register address field |
| rr_rd_hit | output | 1 | Result register hit field |
| res_addr | output | AW | Winning address |
| res_valid | output | 1 | Result valid strobe |
| res_hit | output | 1 | Result hit strobe |

## Verification
Keys are chosen so that each outcome has only one explanation. An exact key that also equals a dead entry at a lower address separates the live check from the priority choice. A key that differs only in a locally uncared bit while matching two entries shows both local don't-care and lowest-address priority. A key one cared bit away from everything yields a clean miss. Searches through the low-half, high-half-by-AND and all-zero mask pairs each predict a different winner or miss, so a wrong pair, a single-register mask or an OR of the pair would each show up. Back-to-back runs with varied result indices and strobe delays separate per-search ordering from latency and from register steering.

// File: rtl/tcam_search72.sv
`timescale 1ns/1ps
module tcam_search72 #(
  parameter int DEPTH = 64,
  parameter int KW    = 72,
  parameter int NGM   = 8,
  parameter int NCR   = 8,
  parameter int NRR   = 8,
  parameter int LATW  = 3,
  parameter int AW    = $clog2(DEPTH),
  parameter int GSW   = $clog2(NGM),
  parameter int CSW   = $clog2(NCR),
  parameter int RSW   = $clog2(NRR)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tw_en,
  input  logic [AW-1:0]   tw_addr,
  input  logic [KW-1:0]   tw_data,
  input  logic [KW-1:0]   tw_care,
  input  logic            tw_live,
  input  logic            gm_we,
  input  logic [GSW-1:0]  gm_sel,
  input  logic [KW-1:0]   gm_wdata,
  input  logic            cmd_a,
  input  logic            cmd_b,
  input  logic [KW-1:0]   cmd_key,
  input  logic [GSW-2:0]  cmd_gpair,
  input  logic [CSW-2:0]  cmd_cpair,
  input  logic [RSW-1:0]  cmd_rsel,
  input  logic [LATW-1:0] lat_extra,
  input  logic [CSW-1:0]  cr_rd_sel,
  output logic [KW-1:0]   cr_rd_data,
  input  logic [RSW-1:0]  rr_rd_sel,
  output logic [AW-1:0]   rr_rd_addr,
  output logic            rr_rd_hit,
  output logic [AW-1:0]   res_addr,
  output logic            res_valid,
  output logic            res_hit
);
  localparam int NDLY = 1 << LATW;

  logic [KW-1:0]    t_data [DEPTH];
  logic [KW-1:0]    t_care [DEPTH];
  logic [DEPTH-1:0] t_live;
  logic [KW-1:0]    gm [NGM];
  logic [KW-1:0]    cr [NCR];
  logic [AW-1:0]    rr_addr [NRR];
  logic [NRR-1:0]   rr_hit;

  always_ff @(posedge clk)
    if (tw_en) begin
      t_data[tw_addr] <= tw_data;
      t_care[tw_addr] <= tw_care;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     t_live <= '0;
    else if (tw_en) t_live[tw_addr] <= tw_live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NGM; i++) gm[i] <= '1;
    end else if (gm_we) begin
      gm[gm_sel] <= gm_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCR; i++) cr[i] <= '0;
    end else if (cmd_b) begin
      cr[{cmd_cpair, 1'b0}] <= cmd_key;
      cr[{cmd_cpair, 1'b1}] <= cmd_key;
    end

  logic             a_v, b_v, m_v, e_v, e_hit;
  logic [KW-1:0]    a_mask, b_mask, b_key;
  logic [RSW-1:0]   a_rs, b_rs, m_rs, e_rs;
  logic [DEPTH-1:0] m_vec;
  logic [AW-1:0]    enc, e_addr;
  logic [NDLY-1:0]  d_v, d_h;

  always_comb begin
    enc = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (m_vec[i]) enc = AW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_v <= 1'b0; b_v <= 1'b0; m_v <= 1'b0; e_v <= 1'b0; e_hit <= 1'b0;
      a_mask <= '0; b_mask <= '0; b_key <= '0;
      a_rs <= '0; b_rs <= '0; m_rs <= '0; e_rs <= '0;
      m_vec <= '0; e_addr <= '0;
      res_addr <= '0; d_v <= '0; d_h <= '0; rr_hit <= '0;
      for (int i = 0; i < NRR; i++) rr_addr[i] <= '0;
    end else begin
      a_v <= cmd_a;
      if (cmd_a) begin
        a_mask <= gm[{cmd_gpair, 1'b0}] & gm[{cmd_gpair, 1'b1}];
        a_rs   <= cmd_rsel;
      end
      b_v <= a_v;
      if (a_v) begin
        b_key  <= cmd_key;
        b_mask <= a_mask;
        b_rs   <= a_rs;
      end
      m_v  <= b_v;
      m_rs <= b_rs;
      for (int i = 0; i < DEPTH; i++)
        m_vec[i] <= b_v && t_live[i] &&
                    (((b_key ^ t_data[i]) & b_mask & t_care[i]) == '0);
      e_v    <= m_v;
      e_rs   <= m_rs;
      e_addr <= enc;
      e_hit  <= |m_vec;
      if (e_v) begin
        res_addr      <= e_addr;
        rr_addr[e_rs] <= e_addr;
        rr_hit[e_rs]  <= e_hit;
      end
      d_v <= {d_v[NDLY-2:0], e_v};
      d_h <= {d_h[NDLY-2:0], e_v & e_hit};
    end

  assign res_valid  = d_v[lat_extra];
  assign res_hit    = d_h[lat_extra];
  assign cr_rd_data = cr[cr_rd_sel];
  assign rr_rd_addr = rr_addr[rr_rd_sel];
  assign rr_rd_hit  = rr_hit[rr_rd_sel];
endmodule

// File: rtl/tcam_search72_chk.sv
`timescale 1ns/1ps
module tcam_search72_chk #(
  parameter int AW = 6,
  parameter int LATW = 3
)(
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_a,
  input logic            cmd_b,
  input logic [LATW-1:0] lat_extra,
  input logic [AW-1:0]   res_addr,
  input logic            res_valid,
  input logic            res_hit
);
  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n) cmd_a |=> cmd_b); // R10
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) res_hit |-> res_valid); // R9
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && lat_extra == '0) |-> res_addr == '0); // R9
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_a, 5) && lat_extra == '0) |-> res_valid); // R8
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_a, 5) |-> $stable(res_addr)); // R8
endmodule

bind tcam_search72 tcam_search72_chk #(.AW(AW), .LATW(LATW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .lat_extra(lat_extra),
  .res_addr(res_addr), .res_valid(res_valid), .res_hit(res_hit));

// File: tb/sim_tcam_search72.sv
`timescale 1ns/1ps
module sim_tcam_search72;
  localparam int DEPTH = 64, KW = 72, AW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic tw_en = 0, tw_live = 0, gm_we = 0, cmd_a = 0, cmd_b = 0;
  logic [AW-1:0] tw_addr = '0;
  logic [KW-1:0] tw_data = '0, tw_care = '0, gm_wdata = '0, cmd_key = '0;
  logic [2:0] gm_sel = '0, cr_rd_sel = '0, rr_rd_sel = '0, cmd_rsel = '0, lat_extra = '0;
  logic [1:0] cmd_gpair = '0, cmd_cpair = '0;
  logic [KW-1:0] cr_rd_data;
  logic [AW-1:0] rr_rd_addr, res_addr;
  logic rr_rd_hit, res_valid, res_hit;

  tcam_search72 u0 (
    .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
    .tw_care(tw_care), .tw_live(tw_live), .gm_we(gm_we), .gm_sel(gm_sel),
    .gm_wdata(gm_wdata), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_key(cmd_key),
    .cmd_gpair(cmd_gpair), .cmd_cpair(cmd_cpair), .cmd_rsel(cmd_rsel),
    .lat_extra(lat_extra), .cr_rd_sel(cr_rd_sel), .cr_rd_data(cr_rd_data),
    .rr_rd_sel(rr_rd_sel), .rr_rd_addr(rr_rd_addr), .rr_rd_hit(rr_rd_hit),
    .res_addr(res_addr), .res_valid(res_valid), .res_hit(res_hit));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [KW-1:0] md [DEPTH];
  logic [KW-1:0] mc [DEPTH];
  bit            ml [DEPTH];
  logic [KW-1:0] mg [8];
  logic [KW-1:0] mcr [8];
  logic [AW-1:0] mra [8];
  bit            mrh [8];

  typedef struct { int due; logic [AW-1:0] addr; bit hit; string tag; } exp_t;
  exp_t qa[$];
  exp_t qv[$];

  task automatic chk(string tag, logic [KW-1:0] act, logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (qa.size() > 0 && qa[0].due == cyc) begin
      e = qa.pop_front();
      chk({e.tag, " addr"}, KW'(res_addr), KW'(e.addr));
    end
    if (qv.size() > 0 && qv[0].due == cyc) begin
      e = qv.pop_front();
      chk({e.tag, " valid"}, KW'(res_valid), KW'(1));
      chk({e.tag, " hit"}, KW'(res_hit), KW'(e.hit));
    end else if (rst_n && res_valid) begin
      chk("R8 unexpected valid", KW'(res_valid), KW'(0));
    end
  end

  task automatic twrite(int a, logic [KW-1:0] d, logic [KW-1:0] c, bit l);
    @(negedge clk); #1;
    tw_en = 1; tw_addr = AW'(a); tw_data = d; tw_care = c; tw_live = l;
    md[a] = d; mc[a] = c; ml[a] = l;
    @(negedge clk); #1;
    tw_en = 0;
  endtask

  task automatic gwrite(int s, logic [KW-1:0] d);
    @(negedge clk); #1;
    gm_we = 1; gm_sel = 3'(s); gm_wdata = d; mg[s] = d;
    @(negedge clk); #1;
    gm_we = 0;
  endtask

  task automatic search(logic [KW-1:0] key, int gp, int cp, int rs, string tag);
    logic [AW-1:0] wa = '0;
    bit hit = 0;
    logic [KW-1:0] em;
    @(negedge clk); #1;
    cmd_b = 0; cmd_a = 1; cmd_key = key; cmd_gpair = 2'(gp); cmd_rsel = 3'(rs);
    em = mg[2*gp] & mg[2*gp+1];
    for (int i = DEPTH - 1; i >= 0; i--)
      if (ml[i] && (((key ^ md[i]) & em & mc[i]) == '0)) begin
        hit = 1; wa = AW'(i);
      end
    qa.push_back('{cyc + 5, wa, hit, tag});
    qv.push_back('{cyc + 5 + int'(lat_extra), wa, hit, tag});
    mra[rs] = wa; mrh[rs] = hit;
    mcr[2*cp] = key; mcr[2*cp+1] = key;
    @(negedge clk); #1;
    cmd_a = 0; cmd_b = 1; cmd_cpair = 2'(cp);
  endtask

  task automatic idle(int n);
    @(negedge clk); #1;
    cmd_b = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 8; i++) begin
      rr_rd_sel = 3'(i); cr_rd_sel = 3'(i);
      #1;
      chk({"R7 ", tag, " rr addr"}, KW'(rr_rd_addr), KW'(mra[i]));
      chk({"R7 ", tag, " rr hit"}, KW'(rr_rd_hit), KW'(mrh[i]));
      chk({"R6 ", tag, " comparand"}, cr_rd_data, mcr[i]);
    end
  endtask

  localparam logic [KW-1:0] K1 = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [KW-1:0] K2 = 72'h3C_F0F0_1111_2222_3333;
  localparam logic [KW-1:0] ONES = '1;
  localparam logic [KW-1:0] LOW36 = {36'h0, {36{1'b1}}};
  localparam logic [KW-1:0] HIGH36 = {{36{1'b1}}, 36'h0};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin md[i] = '0; mc[i] = '0; ml[i] = 0; end
    for (int i = 0; i < 8; i++) begin mg[i] = '1; mcr[i] = '0; mra[i] = '0; mrh[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 res_addr in reset", KW'(res_addr), '0);
    chk("R1 res_valid in reset", KW'(res_valid), '0);
    chk("R1 res_hit in reset", KW'(res_hit), '0);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check_regs("R1 after reset");

    gwrite(0, ONES);  gwrite(1, ONES);
    gwrite(2, LOW36); gwrite(3, LOW36);
    gwrite(4, ONES);  gwrite(5, HIGH36);
    gwrite(6, '0);    gwrite(7, '0);

    twrite(2, K1, ONES, 0);
    twrite(7, K1, ONES, 1);
    twrite(12, K2, ~72'hFF, 1);
    twrite(30, K2, ONES, 1);
    twrite(40, K2 ^ 72'h1, ONES, 1);
    twrite(50, 72'h0, ONES, 1);

    search(K1, 0, 0, 0, "R4 R2 dead entry skipped");
    search(K2 ^ 72'h1, 0, 1, 1, "R3 lowest of several");
    search(K2 ^ 72'h100, 0, 2, 2, "R9 miss");
    search(K1 ^ (72'h1 << 60), 1, 3, 3, "R5 low-half pair");
    search(K1 ^ 72'h8, 2, 1, 4, "R5 AND of pair");
    search(72'h12_3456, 3, 0, 6, "R5 all dont-care");
    search(K2 ^ (72'h1 << 40), 2, 2, 7, "R10 back to back miss");
    idle(12);
    check_regs("R10 run");

    lat_extra = 3'd3;
    idle(2);
    search(K1, 0, 3, 5, "R8 delay 3");
    search(K2, 0, 0, 0, "R8 delay 3 second");
    idle(14);
    lat_extra = 3'd7;
    idle(2);
    search(K2 ^ 72'h100, 0, 1, 1, "R9 R8 miss delay 7");
    idle(16);
    lat_extra = 3'd0;
    idle(10);

    twrite(7, K1, ONES, 0);
    search(K1, 0, 2, 2, "R11 entry removed");
    idle(1);
    twrite(2, K1, ONES, 1);
    search(K1, 0, 3, 3, "R11 entry added");
    idle(12);
    check_regs("R11 end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule